// File: doc/BRIEF.md
# Quadrature Encoder Counter Core

This block is a single-channel 24-bit up/down position counter for an incremental encoder. It takes the encoder's two phase inputs and its index pulse. It can decode them in pulse-plus-direction form or in quadrature at one, two or four counts per encoder cycle. Static configuration inputs select the decode, one of four limit behaviours, an input gate, index loading, index polarity and synchronous index loading. A 24-bit preset input gives the value the index loads and, in the bounded modes, the ceiling of the count.

The lower bound of the count is always zero. Two toggle flags extend the readable range: one flips on every underflow and one on every overflow. Their exclusive-or serves as a 25th count bit. A direction flag reports the sense of the last step. A sticky error flag records an impossible quadrature transition, where both phases change between two samples. All three encoder inputs pass through two-flop synchronizers before the edge logic sees them.

Top module: `quad_counter_core`

## Requirements
- R1: After reset the count is 0, both toggle flags are 0, the direction flag is 1 (up) and the error flag is 0.
- R2: An input change that the first synchronizer flop captures at rising edge k changes the count at rising edge k+2.
- R3: With decode 0 (pulse/direction), each rising edge of phase A counts once: up while phase B is 1, down while phase B is 0. A falling edge of A and any change of B do not count.
- R4: Quadrature order is (A,B) = 00, 10, 11, 01, 00 when moving up, with A leading. With decode 1 (x1), one count is made per encoder cycle: up on the rising edge of A, down on the falling edge of A.
- R5: With decode 2 (x2), both edges of A count. With decode 3 (x4), every single-phase change counts, giving 2 and 4 counts per encoder cycle respectively.
- R6: With limit mode 0 (free run), stepping up from 0xFFFFFF gives 0 and flips the carry flag. Stepping down from 0 gives 0xFFFFFF and flips the borrow flag. The exclusive-or of the two flags acts as count bit 24.
- R7: With limit mode 1 (clamp), a step up at or above the preset holds the count and flips the carry flag. A step down at 0 holds the count and flips the borrow flag.
- R8: With limit mode 3 (modulo), a step up at the preset gives 0 and flips the carry flag. A step down at 0 gives the preset value and flips the borrow flag.
- R9: With limit mode 2 (one-shot), a wrap past 0xFFFFFF or below 0 is made once and flips its flag. After it, further steps leave the count unchanged until an index load or a reset.
- R10: With index loading enabled, a rising edge of the effective index loads the preset into the count. The effective index is the raw index when the polarity input is 1 and its inverse when it is 0. With index loading disabled, an index edge has no effect.
- R11: With synchronous index set and a quadrature decode (1 to 3), an index edge does not load at once. The next count step is replaced by the preset load. With decode 0, the synchronous setting is ignored and the load is immediate.
- R12: The direction flag takes the sense of every count step: 1 for up, 0 for down.
- R13: In a quadrature decode, a sample in which both A and B changed sets the error flag and makes no count. The flag stays set until reset. In decode 0 such a sample never sets the flag.
- R14: With the input enable at 0, A and B make no count, no error and no direction change. The edge history keeps following the inputs, and index loading still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B or direction (asynchronous) |
| enc_idx | input | 1 | Encoder index (asynchronous) |
| cfg_scale | input | 2 | Decode: 0 pulse/direction, 1 x1, 2 x2, 3 x4 |
| cfg_mode | input | 2 | Limit mode: 0 free run, 1 clamp, 2 one-shot, 3 modulo |
| cfg_enable | input | 1 | Gate for phases A and B |
| cfg_idx_load | input | 1 | Index loads the preset when 1 |
| cfg_idx_pol | input | 1 | Index polarity: 1 active high, 0 active low |
| cfg_sync_idx | input | 1 | Defer index load to the next count step |
| cfg_preset | input | 24 | Preset value and ceiling |
| count_val | output | 24 | Current count |
| borrow_tgl | output | 1 | Toggles on each underflow |
| carry_tgl | output | 1 | Toggles on each overflow |
| dir_up | output | 1 | Sense of the last step |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
Every result arrives two rising edges after the first synchronizer flop captures the input. This holds for counts, wraps, flags and index loads alike. One test drives a single edge of A and samples at the falling clock edges between. It shows the count still unchanged after the first and second rising edges and changed only after the third. All other tests change inputs on a falling edge and then wait four full cycles before sampling. Each stimulus has therefore settled before it is checked, and no two stimuli can merge in the edge detector.

// File: rtl/qc_pkg.sv
// Shared encodings for the quadrature counter core.
// Assumes: decode and limit-mode codes are fixed at two bits each.
package qc_pkg;
    typedef enum logic [1:0] {
        SC_PULSE = 2'd0,
        SC_X1    = 2'd1,
        SC_X2    = 2'd2,
        SC_X4    = 2'd3
    } scale_e;

    typedef enum logic [1:0] {
        CM_FREE   = 2'd0,
        CM_CLAMP  = 2'd1,
        CM_ONCE   = 2'd2,
        CM_MODULO = 2'd3
    } mode_e;
endpackage

// File: rtl/qc_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes: each bit is sampled on its own; no coherency between bits.
module qc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/qc_decoder.sv
// Edge decoder: turns synchronized A/B samples into up/down steps and
// flags illegal two-phase transitions. Assumes inputs are synchronized.
// The edge history always follows the inputs, even while disabled.
module qc_decoder
    import qc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   a,
    input  logic   b,
    input  logic   enable,
    input  scale_e scale,
    output logic   step_up,
    output logic   step_dn,
    output logic   illegal
);
    logic pa, pb;
    logic da, db, fwd, hit;

    // Keep the previous sample of both phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa <= 1'b0;
            pb <= 1'b0;
        end else begin
            pa <= a;
            pb <= b;
        end
    end

    // Decide whether this sample is a step, and in which sense.
    always_comb begin
        da  = a ^ pa;
        db  = b ^ pb;
        fwd = da ? (a != b) : (a == b);
        hit = 1'b0;
        unique case (scale)
            SC_PULSE: begin
                hit = a & ~pa;
                fwd = b;
            end
            SC_X1:   hit = da & ~db & ~b;
            SC_X2:   hit = da & ~db;
            SC_X4:   hit = da ^ db;
            default: hit = 1'b0;
        endcase
        step_up = enable & hit & fwd;
        step_dn = enable & hit & ~fwd;
        illegal = enable & (scale != SC_PULSE) & da & db;
    end

    // R12: a sample never steps both ways at once.
    p_one_sense_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));
    // R13: an illegal sample never produces a step.
    p_no_step_on_noise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(step_up || step_dn));
endmodule

// File: rtl/qc_counter.sv
// Count register with limit handling, index load, toggle, direction and
// error flags. Assumes step_up/step_dn are one-cycle, mutually exclusive.
module qc_counter
    import qc_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         illegal,
    input  mode_e        mode,
    input  logic [W-1:0] preset,
    input  logic         idx_evt,
    input  logic         sync_en,
    output logic [W-1:0] cnt,
    output logic         bt,
    output logic         ct,
    output logic         dir,
    output logic         err
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic         halted, pend;
    logic [W-1:0] cnt_n;
    logic         bt_n, ct_n, halted_n, pend_n, load, step;

    // Next-state logic: load, then limit-aware stepping.
    always_comb begin
        step     = step_up | step_dn;
        cnt_n    = cnt;
        bt_n     = bt;
        ct_n     = ct;
        halted_n = halted & (mode == CM_ONCE);
        pend_n   = sync_en & ((pend & ~step) | idx_evt);
        load     = (idx_evt & ~sync_en) | (sync_en & pend & step);
        if (load) begin
            cnt_n    = preset;
            halted_n = 1'b0;
        end else if (step && !halted) begin
            if (step_up) begin
                unique case (mode)
                    CM_CLAMP: begin
                        if (cnt >= preset) ct_n = ~ct;
                        else               cnt_n = cnt + 1'b1;
                    end
                    CM_MODULO: begin
                        if (cnt >= preset) begin
                            cnt_n = '0;
                            ct_n  = ~ct;
                        end else cnt_n = cnt + 1'b1;
                    end
                    default: begin
                        cnt_n = cnt + 1'b1;
                        if (cnt == CNT_MAX) begin
                            ct_n     = ~ct;
                            halted_n = (mode == CM_ONCE);
                        end
                    end
                endcase
            end else begin
                unique case (mode)
                    CM_CLAMP: begin
                        if (cnt == '0) bt_n  = ~bt;
                        else           cnt_n = cnt - 1'b1;
                    end
                    CM_MODULO: begin
                        if (cnt == '0) begin
                            cnt_n = preset;
                            bt_n  = ~bt;
                        end else cnt_n = cnt - 1'b1;
                    end
                    default: begin
                        cnt_n = cnt - 1'b1;
                        if (cnt == '0) begin
                            bt_n     = ~bt;
                            halted_n = (mode == CM_ONCE);
                        end
                    end
                endcase
            end
        end
    end

    // State registers; direction follows every step, error is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            bt     <= 1'b0;
            ct     <= 1'b0;
            dir    <= 1'b1;
            err    <= 1'b0;
            halted <= 1'b0;
            pend   <= 1'b0;
        end else begin
            cnt    <= cnt_n;
            bt     <= bt_n;
            ct     <= ct_n;
            if (step) dir <= step_up;
            err    <= err | illegal;
            halted <= halted_n;
            pend   <= pend_n;
        end
    end

    // R13: once set, the error flag stays set.
    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R12: direction takes the sense of each step.
    p_dir_up_r12: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> dir);
    p_dir_dn_r12: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |=> !dir);
    // R6: free-run wrap at the top reaches 0 and flips carry.
    p_free_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_FREE && step_up && !idx_evt && !pend && !halted && cnt == CNT_MAX)
        |=> (cnt == '0 && ct != $past(ct)));
    // R7: clamp holds the count at or above the ceiling.
    p_clamp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_CLAMP && step_up && !idx_evt && !pend && !halted && cnt >= preset)
        |=> $stable(cnt));
    // R9: a halted one-shot counter does not move without a load.
    p_once_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !idx_evt && !pend) |=> $stable(cnt));
    // R11: a synchronous index edge alone does not change the count.
    p_sync_defer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && idx_evt && !pend && !step) |=> $stable(cnt));
endmodule

// File: rtl/quad_counter_core.sv
// Top of the quadrature counter core: synchronizes encoder inputs, finds
// index edges, decodes A/B and drives the count register.
// Assumes all cfg_* inputs are quasi-static.
module quad_counter_core
    import qc_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic [1:0]       cfg_scale,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_enable,
    input  logic             cfg_idx_load,
    input  logic             cfg_idx_pol,
    input  logic             cfg_sync_idx,
    input  logic [CNT_W-1:0] cfg_preset,
    output logic [CNT_W-1:0] count_val,
    output logic             borrow_tgl,
    output logic             carry_tgl,
    output logic             dir_up,
    output logic             noise_err
);
    localparam int NIN = 3;

    logic [NIN-1:0] sync_q;
    logic           idx_prev, idx_rise, idx_evt, sync_en;
    logic           dec_up, dec_dn, dec_err;
    scale_e         scale;
    mode_e          mode;

    assign scale = scale_e'(cfg_scale);
    assign mode  = mode_e'(cfg_mode);

    qc_sync #(.W(NIN), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({enc_idx, enc_b, enc_a}),
        .d_out (sync_q)
    );

    // Remember the last synchronized index level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_prev <= 1'b0;
        else        idx_prev <= sync_q[2];
    end

    // Index event: rising edge after polarity selection, when enabled.
    always_comb begin
        idx_rise = cfg_idx_pol ? (sync_q[2] & ~idx_prev) : (~sync_q[2] & idx_prev);
        idx_evt  = cfg_idx_load & idx_rise;
        sync_en  = cfg_sync_idx & (scale != SC_PULSE);
    end

    qc_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .a       (sync_q[0]),
        .b       (sync_q[1]),
        .enable  (cfg_enable),
        .scale   (scale),
        .step_up (dec_up),
        .step_dn (dec_dn),
        .illegal (dec_err)
    );

    qc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (dec_up),
        .step_dn (dec_dn),
        .illegal (dec_err),
        .mode    (mode),
        .preset  (cfg_preset),
        .idx_evt (idx_evt),
        .sync_en (sync_en),
        .cnt     (count_val),
        .bt      (borrow_tgl),
        .ct      (carry_tgl),
        .dir     (dir_up),
        .err     (noise_err)
    );

    // R14: with the gate closed the decoder produces nothing.
    p_gate_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !(dec_up || dec_dn || dec_err));
    // R13: pulse/direction decode never reports noise.
    p_pulse_no_err_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (scale == SC_PULSE) |-> !dec_err);
endmodule

// File: tb/quad_counter_core_tb_top.sv
`timescale 1ns/1ps
module quad_counter_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic [1:0]  cfg_scale = 2'd0, cfg_mode = 2'd0;
    logic        cfg_enable = 1'b1, cfg_idx_load = 1'b0, cfg_idx_pol = 1'b1, cfg_sync_idx = 1'b0;
    logic [23:0] cfg_preset = 24'd0;
    logic [23:0] count_val;
    logic        borrow_tgl, carry_tgl, dir_up, noise_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic qa = 1'b0, qb = 1'b0;

    always #2 clk = ~clk;

    quad_counter_core dut_i (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .cfg_scale(cfg_scale), .cfg_mode(cfg_mode), .cfg_enable(cfg_enable),
        .cfg_idx_load(cfg_idx_load), .cfg_idx_pol(cfg_idx_pol), .cfg_sync_idx(cfg_sync_idx),
        .cfg_preset(cfg_preset), .count_val(count_val), .borrow_tgl(borrow_tgl),
        .carry_tgl(carry_tgl), .dir_up(dir_up), .noise_err(noise_err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic move(input logic a, input logic b);
        enc_a = a; enc_b = b; qa = a; qb = b;
        settle();
    endtask

    task automatic q_up();
        if (qa == qb) move(~qa, qb); else move(qa, ~qb);
    endtask

    task automatic q_dn();
        if (qa == qb) move(qa, ~qb); else move(~qa, qb);
    endtask

    task automatic pulse(input logic up);
        move(1'b0, up); move(1'b1, up); move(1'b0, up);
    endtask

    task automatic idx_pulse();
        enc_idx = 1'b1; settle();
        enc_idx = 1'b0; settle();
    endtask

    task automatic load_value(input logic [23:0] v);
        cfg_preset = v; cfg_idx_pol = 1'b1; cfg_idx_load = 1'b1;
        idx_pulse();
        cfg_idx_load = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        enc_a = 0; enc_b = 0; enc_idx = 0; qa = 0; qb = 0;
        cfg_scale = 0; cfg_mode = 0; cfg_enable = 1; cfg_idx_load = 0;
        cfg_idx_pol = 1; cfg_sync_idx = 0; cfg_preset = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count_val, 0);
        check("R1 borrow", borrow_tgl, 0);
        check("R1 carry", carry_tgl, 0);
        check("R1 dir", dir_up, 1);
        check("R1 err", noise_err, 0);
    endtask

    task automatic t_latency();
        do_reset();
        enc_b = 1'b1; settle();
        enc_a = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 after edge k", count_val, 0);
        @(posedge clk); @(negedge clk);
        check("R2 after edge k+1", count_val, 0);
        @(posedge clk); @(negedge clk);
        check("R2 after edge k+2", count_val, 1);
    endtask

    task automatic t_pulse();
        do_reset();
        pulse(1); pulse(1); pulse(1);
        check("R3 three up pulses", count_val, 3);
        move(0, 0); move(0, 1); move(0, 0);
        check("R3 B alone no count", count_val, 3);
        pulse(0);
        check("R3 down pulse", count_val, 2);
        check("R12 dir after down", dir_up, 0);
    endtask

    task automatic t_x1();
        do_reset();
        cfg_scale = 2'd1;
        for (int i = 0; i < 8; i++) q_up();
        check("R4 x1 two cycles up", count_val, 2);
        check("R12 dir up", dir_up, 1);
        for (int i = 0; i < 4; i++) q_dn();
        check("R4 x1 one cycle down", count_val, 1);
        check("R12 dir down", dir_up, 0);
    endtask

    task automatic t_x2_x4();
        do_reset();
        cfg_scale = 2'd2;
        for (int i = 0; i < 4; i++) q_up();
        check("R5 x2 one cycle", count_val, 2);
        cfg_scale = 2'd3;
        for (int i = 0; i < 4; i++) q_up();
        check("R5 x4 one cycle", count_val, 6);
        q_dn();
        check("R5 x4 one down", count_val, 5);
        check("R12 x4 dir", dir_up, 0);
    endtask

    task automatic t_free();
        do_reset();
        load_value(24'hFFFFFF);
        check("R6 loaded top", count_val, 24'hFFFFFF);
        pulse(1);
        check("R6 wrap up", count_val, 0);
        check("R6 carry", carry_tgl, 1);
        check("R6 bit24", {31'd0, borrow_tgl ^ carry_tgl}, 1);
        pulse(0);
        check("R6 wrap down", count_val, 24'hFFFFFF);
        check("R6 borrow", borrow_tgl, 1);
    endtask

    task automatic t_clamp();
        do_reset();
        cfg_mode = 2'd1;
        load_value(24'd5);
        pulse(1);
        check("R7 hold at ceiling", count_val, 5);
        check("R7 carry", carry_tgl, 1);
        for (int i = 0; i < 5; i++) pulse(0);
        check("R7 reach floor", count_val, 0);
        pulse(0);
        check("R7 hold at floor", count_val, 0);
        check("R7 borrow", borrow_tgl, 1);
    endtask

    task automatic t_modulo();
        do_reset();
        cfg_mode = 2'd3;
        load_value(24'd3);
        pulse(1);
        check("R8 wrap to zero", count_val, 0);
        check("R8 carry", carry_tgl, 1);
        pulse(0);
        check("R8 wrap to ceiling", count_val, 3);
        check("R8 borrow", borrow_tgl, 1);
    endtask

    task automatic t_once();
        do_reset();
        cfg_mode = 2'd2;
        load_value(24'hFFFFFF);
        pulse(1);
        check("R9 first wrap", count_val, 0);
        check("R9 carry", carry_tgl, 1);
        pulse(1);
        check("R9 frozen up", count_val, 0);
        pulse(0);
        check("R9 frozen down", count_val, 0);
        check("R9 no borrow while frozen", borrow_tgl, 0);
        load_value(24'hFFFFFF);
        pulse(0);
        check("R9 counts after reload", count_val, 24'hFFFFFE);
    endtask

    task automatic t_index();
        do_reset();
        cfg_preset = 24'h33;
        idx_pulse();
        check("R10 load disabled", count_val, 0);
        cfg_idx_load = 1'b1; cfg_idx_pol = 1'b0;
        enc_idx = 1'b1; settle();
        check("R10 low-active raw rise", count_val, 0);
        enc_idx = 1'b0; settle();
        check("R10 low-active load", count_val, 24'h33);
    endtask

    task automatic t_sync();
        do_reset();
        cfg_scale = 2'd3; cfg_sync_idx = 1'b1; cfg_idx_load = 1'b1; cfg_preset = 24'h40;
        idx_pulse();
        check("R11 deferred", count_val, 0);
        q_up();
        check("R11 step replaced", count_val, 24'h40);
        q_up();
        check("R11 next step counts", count_val, 24'h41);
        cfg_scale = 2'd0; cfg_preset = 24'h10;
        idx_pulse();
        check("R11 pulse mode immediate", count_val, 24'h10);
    endtask

    task automatic t_noise();
        do_reset();
        cfg_scale = 2'd3;
        move(1, 1);
        check("R13 err set", noise_err, 1);
        check("R13 no count", count_val, 0);
        move(0, 1);
        check("R13 counts after", count_val, 1);
        check("R13 sticky", noise_err, 1);
        do_reset();
        move(1, 1);
        check("R13 pulse no err", noise_err, 0);
        check("R13 pulse counted", count_val, 1);
    endtask

    task automatic t_enable();
        do_reset();
        cfg_enable = 1'b0; cfg_scale = 2'd3;
        for (int i = 0; i < 4; i++) q_up();
        move(1, 1);
        check("R14 no count", count_val, 0);
        check("R14 no err", noise_err, 0);
        check("R14 dir kept", dir_up, 1);
        load_value(24'd7);
        check("R14 index still loads", count_val, 7);
        cfg_enable = 1'b1;
        move(0, 1);
        check("R14 history tracked", count_val, 8);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_latency();
        t_pulse();
        t_x1();
        t_x2_x4();
        t_free();
        t_clamp();
        t_modulo();
        t_once();
        t_index();
        t_sync();
        t_noise();
        t_enable();
        done = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            report();
        end
    end
endmodule